// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter Stage

This block is a 4-bit synchronous up counter meant to be chained into multi-digit counters. A parameter fixes its modulus: 10 for a decimal digit that runs 0 to 9, or 16 for a binary nibble that runs 0 to 15. A second parameter chooses the clear style. The clear either acts at once, independent of the clock, or takes effect only at a rising clock edge. Besides the clear, the stage accepts a synchronous parallel preset and two count enables that are ANDed together.

Each cycle the stage selects one operation, held in the enumerated type `op_e`. `OP_CLEAR` is chosen while `clr_n` is low. Otherwise `OP_LOAD` is chosen while `load_n` is low. Otherwise `OP_COUNT` is chosen when `en_p` and `en_t` are both high. In every other case the operation is `OP_HOLD`. The count register then moves to 0, to `din`, to its successor, or stays where it is. In decimal mode the successor map is 0→1→…→9→0 for legal values. Out-of-range values follow 10→11→6, 12→13→4 and 14→15→2. In binary mode the map is 0→1→…→15→0.

`tc` is a combinational decode of the present count and `en_t`. In a chain, the `tc` of one stage drives the `en_t` of the next, and a shared `en_p` gates every stage at once. A carry can therefore ripple through the chain within one cycle.

Top module: `sync_count_stage`

## Requirements
- R1: With `clr_n` and `load_n` high and both enables high, each rising edge moves `q` to its successor. In decimal mode (MODULUS=10) that means q+1 below 9 and 9→0. In binary mode (MODULUS=16) it means q+1 below 15 and 15→0.
- R2: With SYNC_CLEAR=0, a low `clr_n` forces `q` to 0 immediately, before any clock edge. It holds `q` at 0 while it stays low, whatever `load_n`, `din` and the enables are.
- R3: With SYNC_CLEAR=1, a low `clr_n` leaves `q` unchanged until the next rising edge, which sets `q` to 0. This takes priority over both load and count.
- R4: With `clr_n` high and `load_n` low, a rising edge copies `din` into `q`, whatever `en_p` and `en_t` are.
- R5: With `clr_n` and `load_n` high, `q` holds its value across an edge if `en_p` is low or `en_t` is low.
- R6: `tc` is 1 exactly when `en_t` is 1 and `q` equals the top state: 9 (1001) in decimal mode, 15 (1111) in binary mode. For any other `q`, `tc` is 0.
- R7: In decimal mode, a preset of 10 to 15 is accepted. Counting then goes 10→11→6, 12→13→4 and 14→15→2, so `q` is back in 0–9 within two counting edges. `tc` stays 0 in all of these states.
- R8: `tc` follows `q` and `en_t` within the same cycle, with no register. Two decimal stages, with the units `tc` driving the tens `en_t`, count 00 to 99 and wrap to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous per SYNC_CLEAR |
| load_n | input | 1 | Active-low parallel preset enable |
| din | input | WIDTH | Parallel preset value |
| en_p | input | 1 | Count enable that does not affect `tc` |
| en_t | input | 1 | Count enable that also qualifies `tc` |
| q | output | WIDTH | Present count |
| tc | output | 1 | Terminal-count flag |

## Verification
The bench targets the following corner cases:
- **Cascade carry.** The carry from units to tens at every x9 value. A registered or late `tc` would make the tens digit lag by one count.
- **Operation priority, in both clear styles.** A clear asserted together with load and count must win. A synchronous clear that acted early, or a load that lost to count, would show the wrong value.
- **Decode of the top state.** A `tc` that ignored `en_t` or fired at 15 in decimal mode would break chaining.
- **Every illegal decimal preset.** Each is walked through two counting edges. A plain +1 map, or one that wraps to 0, differs at once from the required recovery path.

// File: rtl/sync_count_pkg.sv
package sync_count_pkg;

    // Operation selected for the coming clock edge, in priority order
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

endpackage

// File: rtl/sync_count_op_sel.sv
module sync_count_op_sel
    import sync_count_pkg::*;
(
    input  logic clr_n,
    input  logic load_n,
    input  logic en_p,
    input  logic en_t,
    output op_e  op
);

    // Clear beats load, load beats count, count needs both enables
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/sync_count_next.sv
module sync_count_next
    import sync_count_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] MAXV = WIDTH'(MODULUS - 1);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    // Odd out-of-range values fold back to FOLD - q
    localparam int               FOLD = 2 * MODULUS - 3;

    logic [WIDTH-1:0] succ;

    generate
        if (MODULUS == (1 << WIDTH)) begin : g_full
            // Full binary range: natural wrap of the adder
            assign succ = q + ONE;
        end else begin : g_trunc
            always_comb begin
                if (q == MAXV)
                    succ = '0;
                else if (q < MAXV)
                    succ = q + ONE;
                else if (!q[0])
                    succ = q + ONE;
                else
                    succ = WIDTH'(FOLD - int'(q));
            end
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = succ;
            OP_HOLD:  nxt = q;
            default:  nxt = q;
        endcase
    end

endmodule

// File: rtl/sync_count_tc.sv
module sync_count_tc #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  logic             en_t,
    input  logic [WIDTH-1:0] q,
    output logic             tc
);

    localparam logic [WIDTH-1:0] MAXV = WIDTH'(MODULUS - 1);

    // Full decode of the top state, unregistered so a chain settles in one cycle
    assign tc = en_t && (q == MAXV);

endmodule

// File: rtl/sync_count_stage.sv
module sync_count_stage
    import sync_count_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int MODULUS    = 10,
    parameter bit SYNC_CLEAR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             tc
);

    op_e              op;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] cnt_r;

    sync_count_op_sel u_sel (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    sync_count_next #(
        .WIDTH   (WIDTH),
        .MODULUS (MODULUS)
    ) u_next (
        .op  (op),
        .q   (cnt_r),
        .din (din),
        .nxt (nxt)
    );

    sync_count_tc #(
        .WIDTH   (WIDTH),
        .MODULUS (MODULUS)
    ) u_tc (
        .en_t (en_t),
        .q    (cnt_r),
        .tc   (tc)
    );

    generate
        if (SYNC_CLEAR) begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt_r <= nxt;
            end
        end else begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt_r <= '0;
                else
                    cnt_r <= nxt;
            end
        end
    endgenerate

    assign q = cnt_r;

endmodule

// File: rtl/sync_count_stage_chk.sv
module sync_count_stage_chk #(
    parameter int WIDTH      = 4,
    parameter int MODULUS    = 10,
    parameter bit SYNC_CLEAR = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] q,
    input logic             tc
);

    localparam logic [WIDTH-1:0] MAXV = WIDTH'(MODULUS - 1);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic adv;
    assign adv = load_n && en_p && en_t;

    // R4
    load_takes_din_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));

    // R5
    hold_when_gated_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (adv && q < MAXV) |=> q == $past(q) + ONE);

    // R1
    count_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (adv && q == MAXV) |=> q == '0);

    // R6
    tc_needs_trickle_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> en_t);

    // R6
    tc_only_at_top_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (q != MAXV) |-> !tc);

    generate
        if (SYNC_CLEAR) begin : g_sync
            // R3
            sync_clear_chk: assert property (@(posedge clk)
                !clr_n |=> q == '0);
        end else begin : g_async
            // R2
            async_clear_chk: assert property (@(posedge clk)
                !clr_n |-> q == '0);
        end

        if (MODULUS < (1 << WIDTH)) begin : g_illegal
            // R7
            illegal_exit_chk: assert property (@(posedge clk) disable iff (!clr_n)
                (adv && q > MAXV && q[0]) |=> q <= MAXV);
        end
    endgenerate

endmodule

bind sync_count_stage sync_count_stage_chk #(
    .WIDTH      (WIDTH),
    .MODULUS    (MODULUS),
    .SYNC_CLEAR (SYNC_CLEAR)
) chk_i (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .din    (din),
    .en_p   (en_p),
    .en_t   (en_t),
    .q      (q),
    .tc     (tc)
);

// File: tb/sync_count_stage_test.sv
module sync_count_stage_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Group A: two-digit cascade, asynchronous clear
    logic       clr_a = 1'b1, load_a = 1'b1, enp_a = 1'b0;
    logic [3:0] din_a = 4'd0;
    logic [3:0] q_u, q_t;
    logic       tc_u, tc_t;

    // Group B: decimal and binary stages, synchronous clear
    logic       clr_b = 1'b1, load_b = 1'b1, enp_b = 1'b0, ent_b = 1'b0;
    logic [3:0] din_b = 4'd0;
    logic [3:0] q_sb, q_sx;
    logic       tc_sb, tc_sx;

    sync_count_stage #(.WIDTH(4), .MODULUS(10), .SYNC_CLEAR(1'b0)) uut (
        .clk(clk), .clr_n(clr_a), .load_n(load_a), .din(din_a),
        .en_p(enp_a), .en_t(1'b1), .q(q_u), .tc(tc_u));

    sync_count_stage #(.WIDTH(4), .MODULUS(10), .SYNC_CLEAR(1'b0)) tens_i (
        .clk(clk), .clr_n(clr_a), .load_n(load_a), .din(din_a),
        .en_p(enp_a), .en_t(tc_u), .q(q_t), .tc(tc_t));

    sync_count_stage #(.WIDTH(4), .MODULUS(10), .SYNC_CLEAR(1'b1)) sb_i (
        .clk(clk), .clr_n(clr_b), .load_n(load_b), .din(din_b),
        .en_p(enp_b), .en_t(ent_b), .q(q_sb), .tc(tc_sb));

    sync_count_stage #(.WIDTH(4), .MODULUS(16), .SYNC_CLEAR(1'b1)) sx_i (
        .clk(clk), .clr_n(clr_b), .load_n(load_b), .din(din_b),
        .en_p(enp_b), .en_t(ent_b), .q(q_sx), .tc(tc_sx));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock edge; returns half a period later, away from the edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_bcd(input int v);
        if (v < 9)      return v + 1;
        if (v == 9)     return 0;
        if (v % 2 == 0) return v + 1;
        return 17 - v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v1;
        #1;
        clr_a = 1'b0;
        clr_b = 1'b0;
        step();
        // R2 / R3 reset state
        chk("R2 reset units", q_u, 0);
        chk("R2 reset tens", q_t, 0);
        chk("R3 reset sync bcd", q_sb, 0);
        chk("R3 reset sync bin", q_sx, 0);

        // ---- Group A: cascade 00..99 and back to 00 (R1, R6, R8)
        clr_a = 1'b1;
        enp_a = 1'b1;
        for (int i = 1; i <= 100; i++) begin
            step();
            chk("R8 cascade units", q_u, i % 10);
            chk("R8 cascade tens", q_t, (i / 10) % 10);
            chk("R6 units tc", tc_u, (i % 10 == 9) ? 1 : 0);
            chk("R8 tens tc", tc_t, (i % 100 == 99) ? 1 : 0);
        end

        // R4 load ignores disabled enables
        load_a = 1'b0;
        din_a  = 4'd7;
        enp_a  = 1'b0;
        step();
        chk("R4 load units", q_u, 7);
        chk("R4 load tens", q_t, 7);

        // R5 hold with parallel enable low
        load_a = 1'b1;
        repeat (3) step();
        chk("R5 hold units", q_u, 7);
        chk("R5 hold tens", q_t, 7);

        // R2 asynchronous clear acts between edges and beats load/count
        enp_a  = 1'b1;
        load_a = 1'b0;
        din_a  = 4'd5;
        #1;
        clr_a = 1'b0;
        #1;
        chk("R2 immediate clear units", q_u, 0);
        chk("R2 immediate clear tens", q_t, 0);
        step();
        chk("R2 clear beats load", q_u, 0);
        clr_a  = 1'b1;
        load_a = 1'b1;
        enp_a  = 1'b0;

        // ---- Group B
        clr_b  = 1'b1;
        load_b = 1'b0;
        din_b  = 4'd7;
        step();
        chk("R4 load ignores enables bcd", q_sb, 7);
        chk("R4 load ignores enables bin", q_sx, 7);

        load_b = 1'b1;
        enp_b  = 1'b1;
        ent_b  = 1'b0;
        repeat (2) step();
        chk("R5 hold trickle low", q_sb, 7);
        enp_b = 1'b0;
        ent_b = 1'b1;
        repeat (2) step();
        chk("R5 hold parallel low", q_sx, 7);

        // R3 synchronous clear waits for the edge and wins over load/count
        clr_b  = 1'b0;
        load_b = 1'b0;
        din_b  = 4'd3;
        enp_b  = 1'b1;
        #1;
        chk("R3 no clear before edge", q_sb, 7);
        @(negedge clk);
        step();
        chk("R3 clear beats load bcd", q_sb, 0);
        chk("R3 clear beats load bin", q_sx, 0);
        clr_b = 1'b1;
        din_b = 4'd4;
        step();
        chk("R4 load beats count", q_sb, 4);

        // R6 terminal count decode
        din_b = 4'd9;
        step();
        load_b = 1'b1;
        enp_b  = 1'b0;
        #1;
        chk("R6 tc at 9 bcd", tc_sb, 1);
        chk("R6 no tc at 9 bin", tc_sx, 0);
        ent_b = 1'b0;
        #1;
        chk("R8 tc drops with trickle", tc_sb, 0);
        ent_b  = 1'b1;
        load_b = 1'b0;
        din_b  = 4'd15;
        @(negedge clk);
        step();
        chk("R6 tc at 15 bin", tc_sx, 1);
        chk("R7 no tc at 15 bcd", tc_sb, 0);

        // R1 sweep from 0 in both moduli
        din_b = 4'd0;
        step();
        load_b = 1'b1;
        enp_b  = 1'b1;
        for (int i = 1; i <= 32; i++) begin
            step();
            chk("R1 sweep bcd", q_sb, i % 10);
            chk("R1 sweep bin", q_sx, i % 16);
            chk("R6 sweep tc bin", tc_sx, (i % 16 == 15) ? 1 : 0);
        end

        // R7 every illegal decimal preset
        for (int v = 10; v <= 15; v++) begin
            load_b = 1'b0;
            din_b  = 4'(v);
            step();
            chk("R7 preset accepted", q_sb, v);
            chk("R7 tc low illegal", tc_sb, 0);
            load_b = 1'b1;
            step();
            v1 = exp_bcd(v);
            chk("R7 first step bcd", q_sb, v1);
            chk("R1 bin step", q_sx, (v + 1) % 16);
            step();
            chk("R7 second step bcd", q_sb, exp_bcd(v1));
            chk("R7 back in range", (q_sb <= 4'd9) ? 1 : 0, 1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule